// File: doc/BRIEF.md
# Boundary Test Pattern and Signature Unit

This block sits behind the two rows of boundary cells of a scan-test bus transceiver. There is one row for each bus side, so every pin has a cell on side A and a cell on side B. The unit runs self-test on the I/O boundary, advancing one step per test-clock cycle while the test controller sits in its idle state and raises the step strobe.

On the receiving side it reads pin samples. It can fold them into a parallel signature, with a per-bit mask that removes chosen bits, or it can simply capture them. On the driving side it produces one of three patterns: a pseudorandom sequence, a toggling pattern, or an incrementing binary count. A combined mode folds the inputs into the signature while it counts on the outputs, so a memory behind the pins can be addressed and its read data compacted in the same run.

A direction input picks which side is sampled and which side is driven. Before a run, scan loads the seed for the signature register and the seed for the pattern register. The signature register and the pseudorandom register both use one fixed maximal-length polynomial. New drive values reach the pins on the falling test-clock edge.

Top module: `bts_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the signature and both drive vectors read zero until the first seed load or step.
- R2: A seed load sets the signature to `seed_sig` and the pattern to `seed_pat` at the next rising edge. It takes priority over a step in the same cycle.
- R3: With `step` low and no seed load, the signature and pattern do not change, whatever the mode and samples are.
- R4: In mode 1 (signature), a step sets the signature to the polynomial shift of the old value, XORed with the selected sample. The selected sample is `samp_a` when `a_to_b`=1 and `samp_b` when `a_to_b`=0. The polynomial shift is a right shift that XORs taps 8'hB8 into the result when the old bit 0 was 1.
- R5: A sample bit whose `mask` bit is 1 adds 0 to the signature update.
- R6: In mode 2 (pseudorandom), a step replaces the pattern with its polynomial shift, as defined in R4. The signature holds.
- R7: In mode 3 (toggle), a step inverts every pattern bit and loads the unmasked selected sample into the signature.
- R8: In mode 4 (count), a step adds one to the pattern, wrapping from all ones to zero. The signature holds.
- R9: In mode 5 (signature and count), a step does the R4 signature update and the R8 count at the same time.
- R10: At every falling edge the pattern is copied onto `drv_b` when `a_to_b`=1, or onto `drv_a` when `a_to_b`=0. The other drive vector keeps its value.
- R11: In mode 0, and in the unused codes 6 and 7, a step leaves the signature and the pattern unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | 1 | Advance strobe, high once per idle-state test-clock cycle |
| mode | input | 3 | Operation code, see R4 to R11 |
| a_to_b | input | 1 | 1: sample side A and drive side B; 0: sample side B and drive side A |
| seed_ld | input | 1 | Load both seeds |
| seed_sig | input | W | Seed for the signature register |
| seed_pat | input | W | Seed for the pattern register |
| samp_a | input | W | Samples from the side-A boundary cells |
| samp_b | input | W | Samples from the side-B boundary cells |
| mask | input | W | 1 removes that sample bit from the signature |
| drv_a | output | W | Drive values for the side-A cells |
| drv_b | output | W | Drive values for the side-B cells |
| signature | output | W | Signature register, read out through scan |

## Verification
The assertions take two things for granted. First, `a_to_b` changes only in the half-cycle after a falling edge, so the side chosen at a falling edge matches the value seen at the rising edges around it. Second, the pattern seed for the pseudorandom mode is nonzero. The bench sets every input a moment after a falling edge and clears `step` right after the rising edge it was meant for. It only seeds pseudorandom runs with nonzero values, which keeps every stimulus within these assumptions.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [2:0] {
    M_HOLD      = 3'd0,
    M_PSA       = 3'd1,
    M_PRPG      = 3'd2,
    M_TOGGLE    = 3'd3,
    M_COUNT     = 3'd4,
    M_PSA_COUNT = 3'd5
  } bts_mode_e;

  function automatic logic mode_compacts(input logic [2:0] m);
    return (m == M_PSA) || (m == M_PSA_COUNT);
  endfunction

  function automatic logic mode_counts(input logic [2:0] m);
    return (m == M_COUNT) || (m == M_PSA_COUNT);
  endfunction
endpackage

// File: rtl/bts_sig_reg.sv
module bts_sig_reg #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [2:0]   mode,
  input  logic         seed_ld,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] samp,
  input  logic [W-1:0] mask,
  output logic [W-1:0] sig
);
  import bts_pkg::*;

  function automatic logic [W-1:0] shift_poly(input logic [W-1:0] s);
    return (s >> 1) ^ (s[0] ? TAPS : '0);
  endfunction

  logic psa_adv;
  logic cap_adv;
  logic [W-1:0] folded;

  assign psa_adv = step && !seed_ld && mode_compacts(mode);
  assign cap_adv = step && !seed_ld && (mode == M_TOGGLE);
  assign folded  = samp & ~mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sig <= '0;
    else if (seed_ld) sig <= seed;
    else if (psa_adv) sig <= shift_poly(sig) ^ folded;
    else if (cap_adv) sig <= samp;
  end

  p_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_ld |=> sig == $past(seed));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !seed_ld) |=> $stable(sig));
  p_full_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (psa_adv && (mask == '1)) |=> sig == shift_poly($past(sig)));
  p_sig_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !seed_ld && (mode == M_PRPG || mode == M_COUNT)) |=> $stable(sig));
endmodule

// File: rtl/bts_pat_gen.sv
module bts_pat_gen #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [2:0]   mode,
  input  logic         seed_ld,
  input  logic [W-1:0] seed,
  output logic [W-1:0] pat
);
  import bts_pkg::*;

  function automatic logic [W-1:0] shift_poly(input logic [W-1:0] s);
    return (s >> 1) ^ (s[0] ? TAPS : '0);
  endfunction

  logic prpg_adv;
  logic tog_adv;
  logic cnt_adv;

  assign prpg_adv = step && !seed_ld && (mode == M_PRPG);
  assign tog_adv  = step && !seed_ld && (mode == M_TOGGLE);
  assign cnt_adv  = step && !seed_ld && mode_counts(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pat <= '0;
    else if (seed_ld)  pat <= seed;
    else if (prpg_adv) pat <= shift_poly(pat);
    else if (tog_adv)  pat <= ~pat;
    else if (cnt_adv)  pat <= pat + 1'b1;
  end

  p_prpg_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (prpg_adv && pat != '0) |=> pat != '0);
  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tog_adv |=> (pat ^ $past(pat)) == '1);
  p_count_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_adv && pat == '1) |=> pat == '0);
  p_hold_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !seed_ld && (mode == M_HOLD || mode > M_PSA_COUNT)) |=> $stable(pat));
endmodule

// File: rtl/bts_pin_drive.sv
module bts_pin_drive #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_to_b,
  input  logic [W-1:0] pat,
  output logic [W-1:0] drv_a,
  output logic [W-1:0] drv_b
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_a <= '0;
      drv_b <= '0;
    end else if (a_to_b) begin
      drv_b <= pat;
    end else begin
      drv_a <= pat;
    end
  end

  p_side_a_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_to_b && $past(a_to_b)) |-> $stable(drv_a));
  p_side_b_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_to_b && !$past(a_to_b)) |-> $stable(drv_b));
endmodule

// File: rtl/bts_unit.sv
module bts_unit #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [2:0]   mode,
  input  logic         a_to_b,
  input  logic         seed_ld,
  input  logic [W-1:0] seed_sig,
  input  logic [W-1:0] seed_pat,
  input  logic [W-1:0] samp_a,
  input  logic [W-1:0] samp_b,
  input  logic [W-1:0] mask,
  output logic [W-1:0] drv_a,
  output logic [W-1:0] drv_b,
  output logic [W-1:0] signature
);
  logic [W-1:0] samp_sel;
  logic [W-1:0] pat;

  assign samp_sel = a_to_b ? samp_a : samp_b;

  bts_sig_reg #(.W(W), .TAPS(TAPS)) u_sig (
    .clk(clk), .rst_n(rst_n), .step(step), .mode(mode), .seed_ld(seed_ld),
    .seed(seed_sig), .samp(samp_sel), .mask(mask), .sig(signature)
  );

  bts_pat_gen #(.W(W), .TAPS(TAPS)) u_pat (
    .clk(clk), .rst_n(rst_n), .step(step), .mode(mode), .seed_ld(seed_ld),
    .seed(seed_pat), .pat(pat)
  );

  bts_pin_drive #(.W(W)) u_drv (
    .clk(clk), .rst_n(rst_n), .a_to_b(a_to_b), .pat(pat),
    .drv_a(drv_a), .drv_b(drv_b)
  );

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (signature == '0 && pat == '0));
endmodule

// File: tb/bts_unit_tb.sv
module bts_unit_tb;
  localparam int W = 8;
  localparam logic [W-1:0] TAPS = 8'hB8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0;
  logic [2:0] mode = 3'd0;
  logic a_to_b = 1'b1;
  logic seed_ld = 1'b0;
  logic [W-1:0] seed_sig = '0, seed_pat = '0, samp_a = '0, samp_b = '0, mask = '0;
  logic [W-1:0] drv_a, drv_b, signature;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] m_sig = '0, m_pat = '0, m_da = '0, m_db = '0;

  always #5 clk = ~clk;

  bts_unit #(.W(W), .TAPS(TAPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .step(step), .mode(mode), .a_to_b(a_to_b),
    .seed_ld(seed_ld), .seed_sig(seed_sig), .seed_pat(seed_pat),
    .samp_a(samp_a), .samp_b(samp_b), .mask(mask),
    .drv_a(drv_a), .drv_b(drv_b), .signature(signature)
  );

  // mode(27:25) dir(24) samp_a(23:16) samp_b(15:8) mask(7:0)
  localparam logic [27:0] TBL [10] = '{
    {3'd1, 1'b1, 8'h3C, 8'hFF, 8'h00},
    {3'd1, 1'b0, 8'hFF, 8'h5A, 8'h0F},
    {3'd2, 1'b1, 8'h11, 8'h22, 8'h00},
    {3'd2, 1'b0, 8'h33, 8'h44, 8'h00},
    {3'd3, 1'b1, 8'h81, 8'h00, 8'hFF},
    {3'd3, 1'b0, 8'h00, 8'h7E, 8'h00},
    {3'd4, 1'b1, 8'h55, 8'hAA, 8'h00},
    {3'd5, 1'b1, 8'hC3, 8'h18, 8'hF0},
    {3'd0, 1'b0, 8'h99, 8'h66, 8'h00},
    {3'd7, 1'b1, 8'h12, 8'h34, 8'h00}
  };

  function automatic logic [W-1:0] m_shift(input logic [W-1:0] s);
    logic [W-1:0] n;
    for (int i = 0; i < W - 1; i++) n[i] = s[i+1] ^ (s[0] & TAPS[i]);
    n[W-1] = s[0] & TAPS[W-1];
    return n;
  endfunction

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd1: return "R4";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic st, input logic [2:0] md, input logic dir,
                       input logic [W-1:0] sa, input logic [W-1:0] sb, input logic [W-1:0] mk,
                       input logic sl, input logic [W-1:0] ss, input logic [W-1:0] sp);
    logic [W-1:0] sel;
    @(negedge clk); #1;
    step = st; mode = md; a_to_b = dir; samp_a = sa; samp_b = sb; mask = mk;
    seed_ld = sl; seed_sig = ss; seed_pat = sp;
    sel = dir ? sa : sb;
    if (sl) begin
      m_sig = ss; m_pat = sp;
    end else if (st) begin
      if (md == 3'd1 || md == 3'd5) m_sig = m_shift(m_sig) ^ (sel & ~mk);
      if (md == 3'd3) m_sig = sel;
      if (md == 3'd2) m_pat = m_shift(m_pat);
      if (md == 3'd3) m_pat = ~m_pat;
      if (md == 3'd4 || md == 3'd5) m_pat = m_pat + 1'b1;
    end
    if (dir) m_db = m_pat; else m_da = m_pat;
    @(posedge clk); #1;
    step = 1'b0; seed_ld = 1'b0;
    @(negedge clk); #1;
    chk(req, "signature", signature, m_sig);
    chk("R10", "drv_a", drv_a, m_da);
    chk("R10", "drv_b", drv_b, m_db);
  endtask

  initial begin : watchdog
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "signature in reset", signature, '0);
    chk("R1", "drv_a in reset", drv_a, '0);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "signature after reset", signature, '0);
    chk("R1", "drv_b after reset", drv_b, '0);

    apply("R2", 1'b0, 3'd0, 1'b1, '0, '0, '0, 1'b1, 8'h01, 8'hA5);
    for (int k = 0; k < 10; k++) begin
      apply(tag_of(TBL[k][27:25]), 1'b1, TBL[k][27:25], TBL[k][24],
            TBL[k][23:16], TBL[k][15:8], TBL[k][7:0], 1'b0, '0, '0);
    end

    // R3: no step, mode and samples busy
    apply("R3", 1'b0, 3'd5, 1'b1, 8'hF0, 8'h0F, 8'h00, 1'b0, '0, '0);
    apply("R3", 1'b0, 3'd3, 1'b0, 8'hAB, 8'hCD, 8'h00, 1'b0, '0, '0);
    // R5: full mask, sample has no effect
    apply("R5", 1'b1, 3'd1, 1'b1, 8'hFF, 8'h00, 8'hFF, 1'b0, '0, '0);
    apply("R5", 1'b1, 3'd1, 1'b0, 8'h00, 8'hA7, 8'hA7, 1'b0, '0, '0);
    // R2: seed wins over a count step
    apply("R2", 1'b1, 3'd4, 1'b1, '0, '0, '0, 1'b1, 8'h80, 8'hFF);
    // R8: wrap from all ones
    apply("R8", 1'b1, 3'd4, 1'b1, '0, '0, '0, 1'b0, '0, '0);
    apply("R8", 1'b1, 3'd4, 1'b0, '0, '0, '0, 1'b0, '0, '0);
    // R9: combined with partial mask on side B
    apply("R9", 1'b1, 3'd5, 1'b0, 8'h00, 8'h3F, 8'h0C, 1'b0, '0, '0);
    // R6: longer pseudorandom run
    for (int k = 0; k < 6; k++) apply("R6", 1'b1, 3'd2, 1'b1, 8'h5A, 8'hA5, 8'h00, 1'b0, '0, '0);
    // R11: code 6 holds
    apply("R11", 1'b1, 3'd6, 1'b1, 8'h77, 8'h88, 8'h00, 1'b0, '0, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule